// File: doc/BRIEF.md
# Cache Lock Request Checker

This block screens every cache lock, touch-and-lock and unlock request before it leaves the load/store pipeline. Each request carries a two-bit cache-target code, an instruction kind and the current privilege state. Attributes from address translation arrive with it: the caching-inhibited bit and a fault indication. The block picks exactly one outcome. The request is forwarded to the first-level cache, forwarded to the second-level cache, turned into a data storage interrupt, or dropped as a silent no-op.

A dropped request leaves a sticky "unable to lock" flag that software inspects and later clears. An interrupt caused by the user-mode lock policy raises a separate lock-cause flag next to the interrupt request. This lets the handler tell that case apart from an ordinary translation fault. The verdict is registered and appears one cycle after the request is presented.

Top module: `cl_lock_check`

## Requirements
- R1: A data lock (kind 0) with target code 0, cacheable, first-level data cache enabled, and no trap condition raises `fwd_l1_o` with `fwd_op_o` = 1 (lock) in the cycle after the request.
- R2: Target code 2 on any kind, when no trap or failure applies, raises `fwd_l2_o` only and never `fwd_l1_o`. The op is 2 (unlock) for kinds 1 and 3 and 1 (lock) for kinds 0 and 2.
- R3: A target code other than 0 or 2 produces `noop_o` and sets `unable_o`. It raises no interrupt and no forward strobe.
- R4: A caching-inhibited target produces `noop_o` and sets `unable_o`, whatever the target code.
- R5: With the first-level data cache disabled, a data-side request (kind 0 or 1) with code 0 is a no-op that sets `unable_o`. Instruction-side kinds (2, 3) and code 2 are unaffected by that enable.
- R6: An instruction-side touch-and-lock (kind 2) with code 0 is forwarded to the first level as a plain touch, `fwd_op_o` = 0.
- R7: An instruction-side unlock (kind 3) with code 0 goes to the first level with `fwd_op_o` = 2 and never to the second level.
- R8: In user mode with the user lock enable at 0, any kind raises `dsi_o` and `dsi_lock_o`. Nothing is forwarded and `unable_o` is left unchanged.
- R9: In supervisor mode, or with the user lock enable at 1, no lock-cause interrupt is raised.
- R10: A translation fault has the highest priority. It raises `dsi_o` with `dsi_lock_o` low and forwards nothing.
- R11: `unable_o` stays set until `clr_unable_i` is asserted. A new failure in the same cycle as the clear leaves it set.
- R12: After reset every output is 0.
- R13: Without `req_vld_i` no strobe (`fwd_l1_o`, `fwd_l2_o`, `dsi_o`, `noop_o`) is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_vld_i | input | 1 | Request present this cycle |
| req_kind_i | input | 2 | 0 data lock, 1 data unlock, 2 instr touch-and-lock, 3 instr unlock |
| req_ct_i | input | 2 | Cache-target code |
| user_mode_i | input | 1 | Processor in user mode |
| user_lock_en_i | input | 1 | User-mode locking permitted |
| inhibit_i | input | 1 | Target marked caching-inhibited |
| l1d_en_i | input | 1 | First-level data cache enabled |
| xlate_fault_i | input | 1 | Translation fault or access violation |
| clr_unable_i | input | 1 | Software write of zero to the sticky flag |
| fwd_l1_o | output | 1 | Forward to first-level cache |
| fwd_l2_o | output | 1 | Forward to second-level cache |
| fwd_op_o | output | 2 | Forwarded op: 0 touch, 1 lock, 2 unlock |
| dsi_o | output | 1 | Data storage interrupt request |
| dsi_lock_o | output | 1 | Interrupt caused by user lock policy |
| noop_o | output | 1 | Request dropped as a no-op |
| unable_o | output | 1 | Sticky unable-to-lock flag |

## Verification
A wrong priority in the decode shows up one cycle after the request as a forward strobe where an interrupt or no-op was due. It can also show up as a lock-cause flag on a plain fault. A sticky flag that drops or fails to set is visible on `unable_o` on the cycle right after the failing request. A missed hold is visible on the cycle after the first idle request. The sweep covers every kind, code and attribute combination, and it clears the flag between vectors so that each set is seen on its own.

// File: rtl/cl_lock_pkg.sv
package cl_lock_pkg;
  typedef enum logic [1:0] {
    K_DLOCK   = 2'd0,
    K_DUNLOCK = 2'd1,
    K_ILOCK   = 2'd2,
    K_IUNLOCK = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    OP_TOUCH  = 2'd0,
    OP_LOCK   = 2'd1,
    OP_UNLOCK = 2'd2
  } op_e;

  typedef struct packed {
    logic fwd_l1;
    logic fwd_l2;
    op_e  op;
    logic dsi;
    logic dsi_lock;
    logic noop;
  } verdict_t;
endpackage

// File: rtl/cl_lock_decode.sv
module cl_lock_decode
  import cl_lock_pkg::*;
#(
  parameter int CT_W  = 2,
  parameter int CT_L1 = 0,
  parameter int CT_L2 = 2
) (
  input  logic            vld_i,
  input  kind_e           kind_i,
  input  logic [CT_W-1:0] ct_i,
  input  logic            user_i,
  input  logic            ule_i,
  input  logic            inh_i,
  input  logic            l1d_en_i,
  input  logic            fault_i,
  output verdict_t        verdict_o
);
  logic is_data, is_unlock, tgt_l1, tgt_l2, bad;

  always_comb begin
    is_data   = ~kind_i[1];
    is_unlock = kind_i[0];
    tgt_l1    = (ct_i == CT_W'(CT_L1));
    tgt_l2    = (ct_i == CT_W'(CT_L2));
    bad       = ~(tgt_l1 | tgt_l2) | inh_i | (is_data & tgt_l1 & ~l1d_en_i);
    verdict_o = '0;
    if (!vld_i) begin
      verdict_o = '0;
    end else if (fault_i) begin
      verdict_o.dsi = 1'b1;
    end else if (user_i && !ule_i) begin
      verdict_o.dsi      = 1'b1;
      verdict_o.dsi_lock = 1'b1;
    end else if (bad) begin
      verdict_o.noop = 1'b1;
    end else begin
      verdict_o.fwd_l1 = tgt_l1;
      verdict_o.fwd_l2 = tgt_l2;
      // instruction-side lock at L1 degrades to a touch
      if (is_unlock)            verdict_o.op = OP_UNLOCK;
      else if (!is_data && tgt_l1) verdict_o.op = OP_TOUCH;
      else                      verdict_o.op = OP_LOCK;
    end
  end

  always_comb begin
    a_excl_r3: assert (!(verdict_o.noop && verdict_o.dsi));
  end
endmodule

// File: rtl/cl_lock_sticky.sv
module cl_lock_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(flag_q));
  p_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/cl_lock_check.sv
module cl_lock_check
  import cl_lock_pkg::*;
#(
  parameter int CT_W  = 2,
  parameter int CT_L1 = 0,
  parameter int CT_L2 = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_vld_i,
  input  logic [1:0]      req_kind_i,
  input  logic [CT_W-1:0] req_ct_i,
  input  logic            user_mode_i,
  input  logic            user_lock_en_i,
  input  logic            inhibit_i,
  input  logic            l1d_en_i,
  input  logic            xlate_fault_i,
  input  logic            clr_unable_i,
  output logic            fwd_l1_o,
  output logic            fwd_l2_o,
  output logic [1:0]      fwd_op_o,
  output logic            dsi_o,
  output logic            dsi_lock_o,
  output logic            noop_o,
  output logic            unable_o
);
  verdict_t verdict_d, verdict_q;

  cl_lock_decode #(.CT_W(CT_W), .CT_L1(CT_L1), .CT_L2(CT_L2)) u_decode (
    .vld_i    (req_vld_i),
    .kind_i   (kind_e'(req_kind_i)),
    .ct_i     (req_ct_i),
    .user_i   (user_mode_i),
    .ule_i    (user_lock_en_i),
    .inh_i    (inhibit_i),
    .l1d_en_i (l1d_en_i),
    .fault_i  (xlate_fault_i),
    .verdict_o(verdict_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) verdict_q <= '0;
    else         verdict_q <= verdict_d;
  end

  cl_lock_sticky u_sticky (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (verdict_d.noop),
    .clr_i (clr_unable_i),
    .flag_o(unable_o)
  );

  assign fwd_l1_o   = verdict_q.fwd_l1;
  assign fwd_l2_o   = verdict_q.fwd_l2;
  assign fwd_op_o   = verdict_q.op;
  assign dsi_o      = verdict_q.dsi;
  assign dsi_lock_o = verdict_q.dsi_lock;
  assign noop_o     = verdict_q.noop;

  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fwd_l1_o, fwd_l2_o, dsi_o, noop_o}));
  p_lock_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsi_lock_o |-> dsi_o);
  p_user_trap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_i && user_mode_i && !user_lock_en_i && !xlate_fault_i)
      |=> (dsi_o && dsi_lock_o));
  p_fault_first_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_i && xlate_fault_i) |=> (dsi_o && !dsi_lock_o));
  p_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_vld_i |=> !(fwd_l1_o || fwd_l2_o || dsi_o || noop_o));
endmodule

// File: tb/cl_lock_check_test.sv
module cl_lock_check_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0;
  logic [1:0] kind = '0;
  logic [1:0] ct = '0;
  logic       user = 1'b0, ule = 1'b0, inh = 1'b0, l1en = 1'b1, flt = 1'b0, clr = 1'b0;
  logic       f_l1, f_l2, dsi, dsi_lk, noop, unable;
  logic [1:0] op;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cl_lock_check uut (
    .clk_i(clk), .rst_ni(rst_n), .req_vld_i(vld), .req_kind_i(kind), .req_ct_i(ct),
    .user_mode_i(user), .user_lock_en_i(ule), .inhibit_i(inh), .l1d_en_i(l1en),
    .xlate_fault_i(flt), .clr_unable_i(clr), .fwd_l1_o(f_l1), .fwd_l2_o(f_l2),
    .fwd_op_o(op), .dsi_o(dsi), .dsi_lock_o(dsi_lk), .noop_o(noop), .unable_o(unable)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R12 reset state
    chk("R12", "outputs", {f_l1, f_l2, op, dsi, dsi_lk, noop, unable}, 0);
    rst_n = 1'b1;
    step();
    chk("R13", "idle strobes", {f_l1, f_l2, dsi, noop}, 0);

    for (int k = 0; k < 4; k++)
      for (int c = 0; c < 4; c++)
        for (int m = 0; m < 32; m++) begin
          bit e_l1, e_l2, e_dsi, e_lk, e_noop, is_data, bad;
          int e_op;
          kind = 2'(k); ct = 2'(c);
          {user, ule, inh, l1en, flt} = 5'(m);
          vld = 1'b1; clr = 1'b0;
          is_data = (k < 2);
          bad = !(c == 0 || c == 2) || inh || (is_data && c == 0 && !l1en);
          e_l1 = 0; e_l2 = 0; e_dsi = 0; e_lk = 0; e_noop = 0; e_op = 0;
          if (flt) e_dsi = 1;                          // R10
          else if (user && !ule) begin e_dsi = 1; e_lk = 1; end  // R8
          else if (bad) e_noop = 1;                    // R3 R4 R5
          else begin
            e_l1 = (c == 0); e_l2 = (c == 2);          // R1 R2
            if (k == 1 || k == 3) e_op = 2;            // R7
            else if (k == 2 && c == 0) e_op = 0;       // R6
            else e_op = 1;
          end
          step();
          chk("R1", "fwd_l1", f_l1, e_l1);
          chk("R2", "fwd_l2", f_l2, e_l2);
          chk("R6", "fwd_op", op, e_op);
          chk("R10", "dsi", dsi, e_dsi);
          chk("R9", "dsi_lock", dsi_lk, e_lk);
          chk("R4", "noop", noop, e_noop);
          chk("R3", "unable", unable, e_noop);
          // R11 hold over one idle cycle
          vld = 1'b0;
          step();
          chk("R11", "unable hold", unable, e_noop);
          chk("R13", "idle strobes", {f_l1, f_l2, dsi, noop}, 0);
          clr = 1'b1;
          step();
          chk("R11", "unable clear", unable, 0);
          clr = 1'b0;
        end

    // R11 set wins over clear in the same cycle
    kind = 2'd0; ct = 2'd1; {user, ule, inh, l1en, flt} = 5'b00010;
    vld = 1'b1; clr = 1'b1;
    step();
    chk("R11", "set over clear", unable, 1);
    // R8 trap leaves sticky unchanged
    ct = 2'd0; user = 1'b1; ule = 1'b0; clr = 1'b0;
    step();
    chk("R8", "unable untouched", unable, 1);
    chk("R8", "dsi_lock", dsi_lk, 1);
    vld = 1'b0;
    step();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule